// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and decides which one the processor should serve next. It keeps three 8-bit registers: pending requests (IRR), requests being serviced (ISR) and the mask (IMR). It offers the winning request to the processor as a vector byte. Input 0 has the highest priority. The vector is the upper five bits of a programmed base joined with the 3-bit number of the winning input. A service routine blocks inputs of equal or lower priority until it is ended, either by an end-of-interrupt command or by automatic ending at acknowledge.

Software uses a byte-wide register port with a single address bit. An even-address write with bit 4 set starts a short configuration sequence. The odd-address writes that follow are taken in a fixed order, and then the controller runs. In run mode, odd writes load the mask, and even writes carry end-of-interrupt or readback/mask-mode commands. A master-role controller also names the input of an attached secondary controller on cascade ID lines.

The vector leaves on a valid/ready stream. `vec_valid` is the interrupt request. The processor applies back-pressure by holding `vec_ready` low, and the request stays offered for as long as it does. A transfer happens on a clock edge where both are high. While the request waits, a newly arrived input of higher priority may replace the offered vector. The vector is therefore sampled only at the transfer edge.

Top module: `pic_core`

## Requirements
- R1: After reset, `vec_valid` is low, the mask reads back as 0xFF at the odd address and even-address reads return the IRR.
- R2: An even write with bit 4 set starts configuration. In that word, bit 3 = 1 selects level mode, bit 1 = 1 skips the cascade word, and bit 0 = 1 requests a mode word. The odd writes that follow are taken as vector base, then cascade word, then mode word, each only if required. This start clears ISR and IMR, selects IRR for reads and turns special mask mode off. No request is offered until the sequence completes.
- R3: `vec_data` = {base[7:3], winner index}. The lowest-numbered eligible input wins.
- R4: In run mode an odd write loads the IMR, which reads back at the odd address. A set bit keeps its input from being offered.
- R5: In edge mode a rising input edge sets its IRR bit, which stays set after the input falls. In level mode the IRR bit follows the input, so dropping the line withdraws the request.
- R6: A transfer (`vec_valid` and `vec_ready` high at an edge) clears the winner's IRR bit and sets its ISR bit. With `vec_ready` low the request remains offered.
- R7: Outside special mask mode, while ISR bit i is set, only inputs numbered below i are offered.
- R8: Even write 0x20 (non-specific end) clears the lowest-numbered set ISR bit. Even write 0x60|n (specific end) clears ISR bit n.
- R9: When mode-word bit 1 is set (automatic end), a transfer leaves the ISR unchanged.
- R10: An even write with bits 4:3 = 01 is a readback command. Bits 1:0 = 10 select IRR and 11 select ISR for even reads, and 0x keeps the current choice.
- R11: In the same command, bits 6:5 = 11 set special mask mode and 10 clear it. In special mask mode, any unmasked pending input not itself in service may be offered, whatever the ISR holds.
- R12: Bit 2 of the readback command arms a poll. The next even read returns {pending, 0000, winner index} and, if a request is pending, takes it as a transfer.
- R13: In the master role, when the cascade word marks the winning input, `cas_en` is high with `cas_id` = that input while the request is offered. Otherwise `cas_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_master | input | 1 | 1 = master role, 0 = secondary role |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_in | input | 8 | Interrupt request lines |
| vec_valid | output | 1 | Interrupt request / vector valid |
| vec_ready | input | 1 | Processor accepts the vector |
| vec_data | output | 8 | Vector byte |
| cas_en | output | 1 | Cascade ID lines valid |
| cas_id | output | 3 | Input number of the served secondary |

## Verification
Requests are raised one at a time to check the vector encoding. They are then raised in overlapping pairs, where a lower-priority line arriving during service must stay hidden and a higher-priority one must break through. This separates nesting from plain priority. Masked, back-pressured and cascade-marked inputs show whether the IMR, the ready handshake and the cascade lines act independently. Special mask mode, polling, the two end commands and a reconfiguration into level mode with automatic end each distinguish one ISR update path from the others.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NIRQ  = 8;
  localparam int IDX_W = $clog2(NIRQ);
  localparam int BASE_W = 8 - IDX_W;

  typedef enum logic [1:0] {
    CFG_RUN  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2,
    CFG_MODE = 2'd3
  } cfg_st_e;

  // Index of the lowest-numbered set bit (highest priority); 0 when empty.
  function automatic logic [IDX_W-1:0] low_idx(input logic [NIRQ-1:0] v);
    low_idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (v[i]) low_idx = IDX_W'(i);
  endfunction
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_master,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              init_start,
  output logic              cfg_done,
  output logic              level_mode,
  output logic              auto_end,
  output logic [BASE_W-1:0] vec_base,
  output logic [NIRQ-1:0]   slave_map
);
  cfg_st_e st_q;
  logic    need_casc_q, need_mode_q;
  logic    odd_wr;

  assign init_start = bus_wr && !bus_addr && bus_wdata[4];
  assign odd_wr     = bus_wr && bus_addr;
  assign cfg_done   = (st_q == CFG_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CFG_RUN;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      level_mode  <= 1'b0;
      auto_end    <= 1'b0;
      vec_base    <= '0;
      slave_map   <= '0;
    end else if (init_start) begin
      st_q        <= CFG_BASE;
      level_mode  <= bus_wdata[3];
      need_casc_q <= !bus_wdata[1];
      need_mode_q <= bus_wdata[0];
      auto_end    <= 1'b0;
      slave_map   <= '0;
    end else if (odd_wr) begin
      unique case (st_q)
        CFG_BASE: begin
          vec_base <= bus_wdata[7:IDX_W];
          st_q     <= need_casc_q ? CFG_CASC : (need_mode_q ? CFG_MODE : CFG_RUN);
        end
        CFG_CASC: begin
          slave_map <= role_master ? bus_wdata : '0;
          st_q      <= need_mode_q ? CFG_MODE : CFG_RUN;
        end
        CFG_MODE: begin
          auto_end <= bus_wdata[1];
          st_q     <= CFG_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_irr.sv
module pic_irr
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level_mode,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] take_oh,
  output logic [NIRQ-1:0] irr
);
  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        irr[g] <= 1'b0;
      end else begin
        prev_q <= irq_in[g];
        if (level_mode) irr[g] <= irq_in[g];
        else            irr[g] <= (irr[g] && !take_oh[g]) || (irq_in[g] && !prev_q);
      end
    end
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic [NIRQ-1:0]  irr,
  input  logic [NIRQ-1:0]  imr,
  input  logic [NIRQ-1:0]  isr,
  input  logic             smm,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [NIRQ-1:0] allowed, cand;

  // allowed[i]: no input at or above priority i is in service
  assign allowed[0] = !isr[0];
  for (genvar g = 1; g < NIRQ; g++) begin : g_allow
    assign allowed[g] = allowed[g-1] && !isr[g];
  end

  assign cand = smm ? (irr & ~imr & ~isr) : (irr & ~imr & allowed);
  assign any  = |cand;
  assign idx  = low_idx(cand);
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       role_master,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_in,
  output logic       vec_valid,
  input  logic       vec_ready,
  output logic [7:0] vec_data,
  output logic       cas_en,
  output logic [2:0] cas_id
);
  logic              init_start, cfg_done, level_mode, aeoi_w;
  logic [BASE_W-1:0] vec_base;
  logic [NIRQ-1:0]   slave_map, irr_w, isr_q, isr_d, imr_q, take_oh;
  logic              any_w, take, poll_take;
  logic [IDX_W-1:0]  win_idx;
  logic              rsel_isr_q, smm_q, poll_q;
  logic              cmd_wr, eoi_ns, eoi_sp, ocw_rb;

  pic_cfg u_cfg (
    .clk, .rst_n, .role_master, .bus_wr, .bus_addr, .bus_wdata,
    .init_start, .cfg_done, .level_mode, .auto_end(aeoi_w),
    .vec_base, .slave_map
  );

  pic_irr u_irr (
    .clk, .rst_n, .level_mode, .irq_in, .take_oh, .irr(irr_w)
  );

  pic_resolve u_res (
    .irr(irr_w), .imr(imr_q), .isr(isr_q), .smm(smm_q),
    .any(any_w), .idx(win_idx)
  );

  assign vec_valid = any_w && cfg_done;
  assign vec_data  = {vec_base, win_idx};
  assign cas_en    = vec_valid && role_master && slave_map[win_idx];
  assign cas_id    = cas_en ? win_idx : '0;

  assign poll_take = bus_rd && !bus_addr && poll_q && cfg_done;
  assign take      = vec_valid && (vec_ready || poll_take);
  assign take_oh   = take ? (NIRQ'(1) << win_idx) : '0;

  assign cmd_wr = bus_wr && !bus_addr && cfg_done;
  assign eoi_ns = cmd_wr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'b001;
  assign eoi_sp = cmd_wr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'b011;
  assign ocw_rb = cmd_wr && bus_wdata[4:3] == 2'b01;

  always_comb begin
    isr_d = isr_q;
    if (take && !aeoi_w)      isr_d[win_idx] = 1'b1;
    if (eoi_ns && (|isr_q))   isr_d[low_idx(isr_q)] = 1'b0;
    if (eoi_sp)               isr_d[bus_wdata[IDX_W-1:0]] = 1'b0;
    if (init_start)           isr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q      <= '0;
      imr_q      <= '1;
      rsel_isr_q <= 1'b0;
      smm_q      <= 1'b0;
      poll_q     <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (init_start) begin
        imr_q      <= '0;
        rsel_isr_q <= 1'b0;
        smm_q      <= 1'b0;
        poll_q     <= 1'b0;
      end else begin
        if (bus_wr && bus_addr && cfg_done) imr_q <= bus_wdata;
        if (bus_rd && !bus_addr) poll_q <= 1'b0;
        if (ocw_rb) begin
          if (bus_wdata[1]) rsel_isr_q <= bus_wdata[0];
          if (bus_wdata[6]) smm_q      <= bus_wdata[5];
          if (bus_wdata[2]) poll_q     <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (bus_addr)        bus_rdata = imr_q;
    else if (poll_q)     bus_rdata = {vec_valid, {(7-IDX_W){1'b0}}, win_idx};
    else if (rsel_isr_q) bus_rdata = isr_q;
    else                 bus_rdata = irr_w;
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       role_master,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       vec_valid,
  input logic       vec_ready,
  input logic [7:0] vec_data,
  input logic       cas_en,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q,
  input logic       aeoi,
  input logic       smm,
  input logic       cfg_done
);
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !imr_q[vec_data[2:0]]); // R4

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_wdata[4]) |=> (isr_q == 8'h00 && imr_q == 8'h00)); // R2

  AST_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !vec_valid); // R2

  AST_TAKE_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && !aeoi && !bus_wr) |=> isr_q[$past(vec_data[2:0])]); // R6

  AST_AUTO_END_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && aeoi && !bus_wr) |=> $stable(isr_q)); // R9

  AST_NESTED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !smm) |->
      (({1'b0, isr_q} & ((9'd1 << ({1'b0, vec_data[2:0]} + 4'd1)) - 9'd1)) == 9'd0)); // R7

  AST_CAS_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_en |-> (role_master && vec_valid)); // R13
endmodule

bind pic_core pic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .role_master(role_master),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
  .cas_en(cas_en), .isr_q(isr_q), .imr_q(imr_q), .aeoi(aeoi_w),
  .smm(smm_q), .cfg_done(cfg_done)
);

// File: tb/pic_core_tb_top.sv
module pic_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       role_master = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       vec_valid, vec_ready = 1'b0;
  logic [7:0] vec_data;
  logic       cas_en;
  logic [2:0] cas_id;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rv;

  always #5 clk = ~clk;

  pic_core dut_i (
    .clk, .rst_n, .role_master, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata, .irq_in, .vec_valid, .vec_ready, .vec_data, .cas_en, .cas_id
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // driver: push the expected vector, then grant one ready cycle
  task automatic ack(input logic [7:0] exp);
    exp_q.push_back(exp);
    @(negedge clk); vec_ready = 1'b1;
    @(negedge clk); vec_ready = 1'b0;
  endtask

  // monitor: a transfer is committed at the edge after this sample point
  always begin
    @(negedge clk); #1;
    if (rst_n && vec_valid && vec_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected transfer", vec_data, 8'h00);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(vec_data == e, "R3/R6 scoreboard vector", vec_data, e);
      end
    end
  end

  initial begin
    #1500000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    chk(vec_valid == 1'b0, "R1 valid low after reset", {7'd0, vec_valid}, 8'h00);
    rd(1'b1, rv); chk(rv == 8'hFF, "R1 mask after reset", rv, 8'hFF);
    rd(1'b0, rv); chk(rv == 8'h00, "R1 even read is IRR", rv, 8'h00);

    // R2: edge, cascaded, mode word follows
    wr(1'b0, 8'h11);
    irq_in[0] = 1'b1;
    settle(2);
    chk(vec_valid == 1'b0, "R2 quiet during configuration", {7'd0, vec_valid}, 8'h00);
    irq_in[0] = 1'b0;
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    rd(1'b1, rv); chk(rv == 8'h00, "R2 start clears mask", rv, 8'h00);
    // input 0 edge during config was latched; serve and end it
    settle(1);
    chk(vec_valid && vec_data == 8'h40, "R2 R3 pending after config", vec_data, 8'h40);
    ack(8'h40); wr(1'b0, 8'h20);

    // R3/R5: single edge request
    @(negedge clk) irq_in[5] = 1'b1;
    settle(2);
    chk(vec_valid && vec_data == 8'h45, "R3 vector for input 5", vec_data, 8'h45);
    @(negedge clk) irq_in[5] = 1'b0;
    settle(2);
    chk(vec_valid == 1'b1, "R5 edge stays pending", {7'd0, vec_valid}, 8'h01);
    rd(1'b0, rv); chk(rv == 8'h20, "R10 default IRR read", rv, 8'h20);
    ack(8'h45);
    settle(1);
    chk(vec_valid == 1'b0, "R6 request gone after transfer", {7'd0, vec_valid}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk(rv == 8'h20, "R6 R10 ISR holds input 5", rv, 8'h20);

    // R7/R8: nesting and end commands
    @(negedge clk) irq_in[6] = 1'b1;
    settle(2);
    chk(vec_valid == 1'b0, "R7 lower priority held", {7'd0, vec_valid}, 8'h00);
    @(negedge clk) irq_in[1] = 1'b1;
    settle(2);
    chk(vec_valid && vec_data == 8'h41, "R7 higher priority breaks in", vec_data, 8'h41);
    ack(8'h41);
    wr(1'b0, 8'h20);
    rd(1'b0, rv); chk(rv == 8'h20, "R8 non-specific end clears input 1", rv, 8'h20);
    wr(1'b0, 8'h65);
    settle(1);
    chk(vec_valid && vec_data == 8'h46, "R8 specific end releases input 6", vec_data, 8'h46);
    ack(8'h46); wr(1'b0, 8'h20);
    @(negedge clk) irq_in = '0;

    // R4: masking
    wr(1'b1, 8'h08);
    @(negedge clk) irq_in[3] = 1'b1;
    settle(2);
    chk(vec_valid == 1'b0, "R4 masked input silent", {7'd0, vec_valid}, 8'h00);
    rd(1'b1, rv); chk(rv == 8'h08, "R4 mask readback", rv, 8'h08);
    wr(1'b1, 8'h00);
    settle(1);
    chk(vec_valid && vec_data == 8'h43, "R4 unmask offers input 3", vec_data, 8'h43);
    ack(8'h43); wr(1'b0, 8'h20);
    @(negedge clk) irq_in = '0;

    // R13: cascade-marked input 2
    @(negedge clk) irq_in[2] = 1'b1;
    settle(2);
    chk(cas_en && cas_id == 3'd2, "R13 cascade lines for input 2", {5'd0, cas_id}, 8'h02);
    ack(8'h42); wr(1'b0, 8'h20);

    // R6: back-pressure on input 4
    @(negedge clk) irq_in[4] = 1'b1;
    settle(6);
    chk(vec_valid && vec_data == 8'h44, "R6 held under back-pressure", vec_data, 8'h44);
    chk(cas_en == 1'b0, "R13 no cascade for input 4", {7'd0, cas_en}, 8'h00);
    ack(8'h44);

    // R11: special mask mode with input 4 in service
    wr(1'b1, 8'h10);
    @(negedge clk) irq_in[6] = 1'b0;
    @(negedge clk) irq_in[6] = 1'b1;
    settle(2);
    chk(vec_valid == 1'b0, "R11 blocked without special mask", {7'd0, vec_valid}, 8'h00);
    wr(1'b0, 8'h68);
    settle(1);
    chk(vec_valid && vec_data == 8'h46, "R11 special mask lets input 6", vec_data, 8'h46);
    wr(1'b0, 8'h48);
    settle(1);
    chk(vec_valid == 1'b0, "R11 special mask cleared", {7'd0, vec_valid}, 8'h00);
    wr(1'b0, 8'h64);
    settle(1);
    ack(8'h46); wr(1'b0, 8'h20);
    wr(1'b1, 8'h00);
    @(negedge clk) irq_in = '0;

    // R12: poll
    wr(1'b0, 8'h0C);
    @(negedge clk) irq_in[7] = 1'b1;
    settle(2);
    rd(1'b0, rv); chk(rv == 8'h87, "R12 poll word", rv, 8'h87);
    rd(1'b0, rv); chk(rv == 8'h80, "R12 poll took input 7", rv, 8'h80);
    wr(1'b0, 8'h20);
    @(negedge clk) irq_in = '0;
    settle(2);

    // R2/R5/R9: level, single, automatic end
    wr(1'b0, 8'h1B);
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h03);
    rd(1'b1, rv); chk(rv == 8'h00, "R2 mode word not taken as mask", rv, 8'h00);
    rd(1'b0, rv); chk(rv == 8'h00, "R2 reads select IRR again", rv, 8'h00);
    @(negedge clk) irq_in[2] = 1'b1;
    settle(2);
    chk(vec_valid && vec_data == 8'h82, "R5 level request", vec_data, 8'h82);
    chk(cas_en == 1'b0, "R13 no cascade in single mode", {7'd0, cas_en}, 8'h00);
    @(negedge clk) irq_in[2] = 1'b0;
    settle(2);
    chk(vec_valid == 1'b0, "R5 level withdrawn", {7'd0, vec_valid}, 8'h00);
    @(negedge clk) irq_in[3] = 1'b1;
    settle(2);
    ack(8'h83);
    irq_in[3] = 1'b0;
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk(rv == 8'h00, "R9 automatic end leaves ISR clear", rv, 8'h00);

    settle(2);
    chk(exp_q.size() == 0, "R6 all expected transfers seen", 8'(exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule